// File: doc/BRIEF.md
# UART Modem Line Interface

This block handles the modem-control and modem-status lines of a serial port. Two output pins, the data-terminal-ready and request-to-send lines, take their level from bits in a control register. The pin level is the logical inverse of the stored bit. The same register holds a loopback control bit and a break-transmit control bit. These two bits leave the block as plain outputs so that the serializer can use them.

Four input lines are synchronised to the block clock: ring indicator, clear-to-send, carrier detect and data-set-ready. Their levels can be read in a status register. Transitions on clear-to-send and carrier detect are watched. When a line's enable bit is set, a rising edge on that line sets the line's pending flag. A falling edge also sets it when the line's any-edge bit is set. Any pending flag raises the external-input interrupt, provided the interrupt's mask bit is set. Software clears the pending flags by reading the status register. An edge that arrives in the same cycle as that read is kept.

Software reaches the registers through a simple strobe bus. A write strobe updates the addressed register. A read strobe marks a read that has side effects. Read data is combinational from the address. Character framing and FIFOs belong to other blocks.

Top module: `mdm_line_if`

## Requirements
- R1: After reset the dtr_o, rts_o, loop_o, brk_o and ext_irq_o outputs are all low. The control register (address 0) reads back 0x03. The edge-config register (address 1), the interrupt-mask register (address 2) and the two pending bits read as 0.
- R2: The control register at address 0 has four fields: bit 0 is the DTR bit, bit 1 the RTS bit, bit 2 the loopback bit and bit 3 the break bit. From the cycle after a write, dtr_o equals the inverse of bit 0 and rts_o the inverse of bit 1. loop_o equals bit 2 and brk_o equals bit 3. The register reads back the written value in bits 3:0.
- R3: At address 3, status bits 0 to 3 show the synchronised levels of ri_i, cts_i, dcd_i and dsr_i, in that order. A change on a pin reaches these bits two clock edges after it is sampled.
- R4: The edge-config register at address 1 has four fields: bit 0 enables CTS edge detection, bit 1 enables DCD edge detection, bit 2 selects any-edge mode for CTS and bit 3 selects any-edge mode for DCD. With detection enabled, a rising edge on a line sets that line's pending bit. The CTS pending bit is status bit 4 and the DCD pending bit is status bit 5.
- R5: With detection enabled, a falling edge sets the pending bit only when the line's any-edge bit is set. Otherwise a falling edge is ignored.
- R6: With a line's enable bit clear, no edge on that line sets its pending bit.
- R7: A read strobe at address 3 returns the pending bits as they were before the read, then clears them on that clock edge.
- R8: If an edge is detected in the same cycle as a clearing status read, the pending bit for that edge stays set after the read.
- R9: ext_irq_o is high exactly when bit 0 of the interrupt-mask register (address 2) is set and at least one pending bit is set.
- R10: A write to the status address (3) changes nothing. The pending and level bits read the same before and after such a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (status read has side effects) |
| addr | input | ADDR_W | Register address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for the addressed register |
| ri_i | input | 1 | Ring indicator input pin |
| cts_i | input | 1 | Clear-to-send input pin |
| dcd_i | input | 1 | Carrier detect input pin |
| dsr_i | input | 1 | Data-set-ready input pin |
| dtr_o | output | 1 | Data-terminal-ready output pin (inverse of control bit) |
| rts_o | output | 1 | Request-to-send output pin (inverse of control bit) |
| loop_o | output | 1 | Loopback control to the serializer |
| brk_o | output | 1 | Break-transmit control to the serializer |
| ext_irq_o | output | 1 | Masked external-input interrupt |

## Verification
The bench covers every combination of line, enable bit, any-edge bit and edge direction. A design that ignored the any-edge setting would either miss falling edges or flag them when it should not. A design that left out the enable gate would flag edges on a disabled line. All 16 control words and all 16 input-level patterns are swept, which catches a pin that is not inverted or a status bit in the wrong position. The bench also places an edge on the exact clock edge of a clearing read. A design in which the clear takes priority over the set would lose that edge silently.

// File: rtl/mdm_pkg.sv
package mdm_pkg;

    localparam int NUM_IN    = 4;   // ri, cts, dcd, dsr
    localparam int NUM_WATCH = 2;   // cts, dcd

    localparam int IDX_RI  = 0;
    localparam int IDX_CTS = 1;
    localparam int IDX_DCD = 2;
    localparam int IDX_DSR = 3;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_EDGE = 2'd1;
    localparam logic [1:0] ADDR_IRQ  = 2'd2;
    localparam logic [1:0] ADDR_STAT = 2'd3;

    typedef struct packed {
        logic                 dtr_bit;
        logic                 rts_bit;
        logic                 loop_bit;
        logic                 brk_bit;
        logic [NUM_WATCH-1:0] det_en;
        logic [NUM_WATCH-1:0] any_edge;
        logic                 irq_en;
        logic [NUM_WATCH-1:0] pend;
    } mdm_state_t;

endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [STAGES-1:0][WIDTH-1:0] sh_d, sh_q;

    always_comb begin
        sh_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            sh_d[i] = sh_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/mdm_edge.sv
module mdm_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    input  logic en,
    input  logic any_edge,
    output logic evt
);
    logic prev_d, prev_q;
    logic rise, fall;

    always_comb begin
        prev_d = lvl;
        rise   = lvl & ~prev_q;
        fall   = ~lvl & prev_q;
        evt    = en & (rise | (any_edge & fall));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/mdm_line_if.sv
module mdm_line_if
    import mdm_pkg::*;
#(
    parameter int ADDR_W      = 2,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              ri_i,
    input  logic              cts_i,
    input  logic              dcd_i,
    input  logic              dsr_i,
    output logic              dtr_o,
    output logic              rts_o,
    output logic              loop_o,
    output logic              brk_o,
    output logic              ext_irq_o
);
    localparam int PEND_LSB = NUM_IN;

    mdm_state_t st_d, st_q;

    logic [NUM_IN-1:0]    pins_raw, pins_sync;
    logic [NUM_WATCH-1:0] watch_lvl, evt_w, pend_w, en_w;
    logic                 stat_rd;

    assign pins_raw = {dsr_i, dcd_i, cts_i, ri_i};

    mdm_sync #(.WIDTH(NUM_IN), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pins_raw),
        .dout  (pins_sync)
    );

    assign watch_lvl = {pins_sync[IDX_DCD], pins_sync[IDX_CTS]};

    for (genvar g = 0; g < NUM_WATCH; g++) begin : g_edge
        mdm_edge u_edge (
            .clk      (clk),
            .rst_n    (rst_n),
            .lvl      (watch_lvl[g]),
            .en       (st_q.det_en[g]),
            .any_edge (st_q.any_edge[g]),
            .evt      (evt_w[g])
        );
    end

    assign stat_rd = rd_en && (addr == ADDR_W'(ADDR_STAT));

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (addr)
                ADDR_W'(ADDR_CTRL): begin
                    st_d.dtr_bit  = wdata[0];
                    st_d.rts_bit  = wdata[1];
                    st_d.loop_bit = wdata[2];
                    st_d.brk_bit  = wdata[3];
                end
                ADDR_W'(ADDR_EDGE): begin
                    st_d.det_en   = wdata[1:0];
                    st_d.any_edge = wdata[3:2];
                end
                ADDR_W'(ADDR_IRQ): begin
                    st_d.irq_en   = wdata[0];
                end
                default: ;
            endcase
        end
        // new edges win over the clearing read
        st_d.pend = evt_w | (st_q.pend & ~{NUM_WATCH{stat_rd}});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.dtr_bit <= 1'b1;
            st_q.rts_bit <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_W'(ADDR_CTRL): rdata[3:0] = {st_q.brk_bit, st_q.loop_bit,
                                              st_q.rts_bit, st_q.dtr_bit};
            ADDR_W'(ADDR_EDGE): rdata[3:0] = {st_q.any_edge, st_q.det_en};
            ADDR_W'(ADDR_IRQ):  rdata[0]   = st_q.irq_en;
            default: begin
                rdata[NUM_IN-1:0]                  = pins_sync;
                rdata[PEND_LSB+NUM_WATCH-1:PEND_LSB] = st_q.pend;
            end
        endcase
    end

    assign pend_w    = st_q.pend;
    assign en_w      = st_q.det_en;
    assign dtr_o     = ~st_q.dtr_bit;
    assign rts_o     = ~st_q.rts_bit;
    assign loop_o    = st_q.loop_bit;
    assign brk_o     = st_q.brk_bit;
    assign ext_irq_o = st_q.irq_en & (|st_q.pend);
endmodule

// File: rtl/mdm_line_if_chk.sv
module mdm_line_if_chk #(
    parameter int ADDR_W = 2,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic              dtr_o,
    input logic              rts_o,
    input logic              ext_irq_o,
    input logic [1:0]        pend_w,
    input logic [1:0]        en_w,
    input logic [1:0]        evt_w
);
    AST_DTR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(0)) |=> (dtr_o == !$past(wdata[0]))); // R2
    AST_RTS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(0)) |=> (rts_o == !$past(wdata[1]))); // R2
    AST_CTS_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_w[0]) |-> $past(en_w[0])); // R6
    AST_DCD_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_w[1]) |-> $past(en_w[1])); // R6
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADDR_W'(3) && evt_w == 2'b00) |=> (pend_w == 2'b00)); // R7
    AST_EDGE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_w != 2'b00) |=> ((pend_w & $past(evt_w)) == $past(evt_w))); // R8
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_w == 2'b00) |-> !ext_irq_o); // R9
endmodule

bind mdm_line_if mdm_line_if_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .addr      (addr),
    .wdata     (wdata),
    .dtr_o     (dtr_o),
    .rts_o     (rts_o),
    .ext_irq_o (ext_irq_o),
    .pend_w    (pend_w),
    .en_w      (en_w),
    .evt_w     (evt_w)
);

// File: tb/tb_mdm_line_if.sv
module tb_mdm_line_if;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       ri_i = 0, cts_i = 0, dcd_i = 0, dsr_i = 0;
    logic       dtr_o, rts_o, loop_o, brk_o, ext_irq_o;

    int  n_run = 0, n_fail = 0;
    bit  done = 0;

    always #10 clk = ~clk;

    mdm_line_if dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .ri_i(ri_i), .cts_i(cts_i), .dcd_i(dcd_i),
        .dsr_i(dsr_i), .dtr_o(dtr_o), .rts_o(rts_o), .loop_o(loop_o),
        .brk_o(brk_o), .ext_irq_o(ext_irq_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1; addr = a; wdata = d;
        @(negedge clk); wr_en = 0;
    endtask

    // peek: no side effects
    task automatic peek(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); addr = a; #1 d = rdata;
    endtask

    // strobed read: clears pending on status
    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); rd_en = 1; addr = a; #1 d = rdata;
        @(negedge clk); rd_en = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        logic [7:0] v;
        idle(3); rst_n = 1; idle(1);
        // R1 reset state
        chk("R1 dtr", dtr_o, 0); chk("R1 rts", rts_o, 0);
        chk("R1 loop", loop_o, 0); chk("R1 brk", brk_o, 0);
        chk("R1 irq", ext_irq_o, 0);
        peek(0, v); chk("R1 ctrl", v, 8'h03);
        peek(1, v); chk("R1 edgecfg", v, 0);
        peek(2, v); chk("R1 irqmask", v, 0);
        peek(3, v); chk("R1 pend", v[5:4], 0);

        // R2 control sweep
        for (int c = 0; c < 16; c++) begin
            wr(0, 8'(c));
            chk("R2 dtr", dtr_o, ~c & 1);
            chk("R2 rts", rts_o, (~c >> 1) & 1);
            chk("R2 loop", loop_o, (c >> 2) & 1);
            chk("R2 brk", brk_o, (c >> 3) & 1);
            peek(0, v); chk("R2 readback", v[3:0], c);
        end

        // R3 level sweep (edge detection disabled)
        for (int p = 0; p < 16; p++) begin
            @(negedge clk);
            ri_i = p[0]; cts_i = p[1]; dcd_i = p[2]; dsr_i = p[3];
            @(negedge clk); @(negedge clk); // two edges
            #1 addr = 3; #1 chk("R3 levels", rdata[3:0], p);
            chk("R6 no pend when disabled", rdata[5:4], 0);
        end
        @(negedge clk); {ri_i, cts_i, dcd_i, dsr_i} = 0; idle(4);

        // R4/R5/R6/R9 sweep over line, enable, any-edge, direction, mask
        for (int line = 0; line < 2; line++)
            for (int en = 0; en < 2; en++)
                for (int any = 0; any < 2; any++)
                    for (int dir = 0; dir < 2; dir++) begin
                        int exp_p;
                        wr(1, 0);
                        @(negedge clk);
                        if (line == 0) cts_i = (dir == 1); else dcd_i = (dir == 1);
                        idle(4);
                        rd(3, v);
                        wr(2, 8'(en ^ dir));
                        wr(1, 8'(((any << 2) | en) << line));
                        @(negedge clk);
                        if (line == 0) cts_i = (dir == 0); else dcd_i = (dir == 0);
                        idle(5);
                        exp_p = en & ((dir == 0) | any);
                        peek(3, v);
                        if (dir == 0) chk("R4 rise pend", v[4 + line], exp_p);
                        else if (en == 1) chk("R5 fall pend", v[4 + line], exp_p);
                        else chk("R6 disabled pend", v[4 + line], exp_p);
                        chk("R4 other line quiet", v[5 - line], 0);
                        chk("R9 irq", ext_irq_o, exp_p & (en ^ dir));
                        wr(3, 8'hFF);
                        peek(3, v); chk("R10 status write ignored", v[4 + line], exp_p);
                        rd(3, v); chk("R7 read returns pend", v[4 + line], exp_p);
                        peek(3, v); chk("R7 read clears", v[5:4], 0);
                        @(negedge clk); cts_i = 0; dcd_i = 0; wr(1, 0); idle(4);
                    end

        // R8 edge coincident with clearing read
        wr(2, 1);
        wr(1, 8'h01);
        @(negedge clk); cts_i = 1;
        @(posedge clk); @(posedge clk);
        @(negedge clk); rd_en = 1; addr = 3;
        @(negedge clk); rd_en = 0;
        peek(3, v); chk("R8 edge kept at clear", v[4], 1);
        chk("R9 irq with kept edge", ext_irq_o, 1);
        rd(3, v); peek(3, v); chk("R7 later read clears", v[4], 0);
        chk("R9 irq low after clear", ext_irq_o, 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule